// File: doc/BRIEF.md
# Vsync-Shadowed Frame Base Address Registers

This block holds the frame buffer start addresses for a display controller. There are two of them. The upper address serves TFT panels, single-panel passive displays and the top half of a dual-panel display. The lower address serves the bottom half of a dual-panel display. Software programs both through a small register bus. The display fetch engine does not read the programmed values. It reads a second pair of "current" registers, and those change only at defined moments.

A vertical sync pulse copies both programmed addresses into the current pair. The same pulse sets a base-update status flag, which tells software that both addresses may now be rewritten for the next frame. When the mask bit is set, the flag also drives an interrupt line. Because of this, software can swap buffers at any point in a frame without tearing. The current pair is also loaded when the controller enable bit goes from 0 to 1, so the first frame starts from a valid address. The flag stays set until software writes 1 to the clear register.

Top module: `fbase_shadow`

Register map, as byte offsets:
- 0x00: control. Bit 0 is the enable.
- 0x04: upper base.
- 0x08: lower base.
- 0x0C: interrupt mask. Bit 0 is the mask.
- 0x10: raw status. Read-only, bit 0.
- 0x14: masked status. Read-only, bit 0.
- 0x18: clear. Write-only, bit 0.

## Requirements
- R1: After reset, both programmed bases, both current bases, the status flag, the mask, the enable and `irq` are all zero.
- R2: A write to the upper base (0x04) or the lower base (0x08) stores bits 31:2. Reading that register back returns those bits with bits 1:0 forced to zero.
- R3: `cur_upper` and `cur_lower` do not change, whatever the bus writes, except on the clock edge that follows a vsync pulse or an enable rise.
- R4: The edge after a vsync pulse loads both current registers with the programmed values held before that edge. A base write in the same cycle as vsync reaches the current registers only at the next vsync.
- R5: In the cycle after control bit 0 changes from 0 to 1, the next edge loads both current registers. Writing 1 while the enable is already 1 loads nothing.
- R6: A vsync pulse sets the status flag, and raw status bit 0 reads 1 from the next cycle. A load caused by the enable rise does not set the flag.
- R7: Writing 1 to clear bit 0 (0x18) resets the flag. Writing 0 there has no effect. If vsync arrives in the same cycle as the clear, the flag stays set.
- R8: `irq` and masked status bit 0 (0x14) both equal the status flag AND the mask bit (0x0C bit 0). Once asserted, they stay asserted until the flag is cleared or the mask is removed.
- R9: Writes to the read-only status registers are ignored. Reads from unmapped offsets return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vsync | input | 1 | Single-cycle vertical sync event |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the selected register |
| cur_upper | output | 32 | Current upper base, to the fetch engine |
| cur_lower | output | 32 | Current lower base, to the fetch engine |
| irq | output | 1 | Base-update interrupt request |

## Verification
The assertions assume that `vsync` is a single-cycle pulse and that `bus_wdata` and `bus_addr` are stable while `bus_sel` is high. The bench drives every access and pulse for exactly one clock, starting just after a rising edge, so both assumptions hold. The clear-on-write check also assumes that no vsync arrives in the same cycle as the clear. The bench therefore tests the collision between vsync and clear separately, through a read-back check rather than through that assertion.

// File: rtl/fbase_pkg.sv
package fbase_pkg;
  localparam int DATA_W     = 32;
  localparam int ADDR_W     = 5;
  localparam int ALIGN_BITS = 2;
  localparam int NUM_PANELS = 2;

  localparam logic [ADDR_W-1:0] OFS_CTRL  = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_UPPER = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_LOWER = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_MASK  = 5'h0C;
  localparam logic [ADDR_W-1:0] OFS_RAW   = 5'h10;
  localparam logic [ADDR_W-1:0] OFS_MSTAT = 5'h14;
  localparam logic [ADDR_W-1:0] OFS_CLEAR = 5'h18;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_CTRL, SEL_UPPER, SEL_LOWER,
    SEL_MASK, SEL_RAW, SEL_MSTAT, SEL_CLEAR
  } reg_sel_e;

  function automatic reg_sel_e decode_ofs(input logic [ADDR_W-1:0] ofs);
    case (ofs)
      OFS_CTRL:  return SEL_CTRL;
      OFS_UPPER: return SEL_UPPER;
      OFS_LOWER: return SEL_LOWER;
      OFS_MASK:  return SEL_MASK;
      OFS_RAW:   return SEL_RAW;
      OFS_MSTAT: return SEL_MSTAT;
      OFS_CLEAR: return SEL_CLEAR;
      default:   return SEL_NONE;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] word_align(input logic [DATA_W-1:ALIGN_BITS] hi);
    return {hi, {ALIGN_BITS{1'b0}}};
  endfunction
endpackage

// File: rtl/fbase_regbank.sv
module fbase_regbank
  import fbase_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [NUM_PANELS-1:0][DATA_W-1:0] prog_base,
  output logic              ctrl_en,
  output logic              irq_mask,
  output logic              clr_hit
);
  reg_sel_e wsel;
  logic     wr_evt;

  assign wsel   = decode_ofs(bus_addr);
  assign wr_evt = bus_sel & bus_wr;

  for (genvar p = 0; p < NUM_PANELS; p++) begin : g_panel
    localparam reg_sel_e MY_SEL = (p == 0) ? SEL_UPPER : SEL_LOWER;
    logic [DATA_W-1:ALIGN_BITS] hi_q;
    always_ff @(posedge clk) begin
      if (!rst_n)                          hi_q <= '0;
      else if (wr_evt && wsel == MY_SEL)   hi_q <= bus_wdata[DATA_W-1:ALIGN_BITS];
    end
    assign prog_base[p] = word_align(hi_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_en  <= 1'b0;
      irq_mask <= 1'b0;
    end else if (wr_evt) begin
      if (wsel == SEL_CTRL) ctrl_en  <= bus_wdata[0];
      if (wsel == SEL_MASK) irq_mask <= bus_wdata[0];
    end
  end

  assign clr_hit = wr_evt && (wsel == SEL_CLEAR) && bus_wdata[0];
endmodule

// File: rtl/fbase_current.sv
module fbase_current
  import fbase_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic vsync,
  input  logic ctrl_en,
  input  logic [NUM_PANELS-1:0][DATA_W-1:0] prog_base,
  output logic [NUM_PANELS-1:0][DATA_W-1:0] cur_base,
  output logic load_evt
);
  logic en_prev;
  logic en_rise;

  always_ff @(posedge clk) begin
    if (!rst_n) en_prev <= 1'b0;
    else        en_prev <= ctrl_en;
  end

  assign en_rise  = ctrl_en & ~en_prev;
  assign load_evt = vsync | en_rise;

  for (genvar p = 0; p < NUM_PANELS; p++) begin : g_cur
    always_ff @(posedge clk) begin
      if (!rst_n)        cur_base[p] <= '0;
      else if (load_evt) cur_base[p] <= prog_base[p];
    end

    // R3: the current base holds between load events
    a_r3_cur_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !load_evt |=> $stable(cur_base[p]));
    // R4: a vsync copies the value programmed before the edge
    a_r4_vsync_copy: assert property (@(posedge clk) disable iff (!rst_n)
      vsync |=> cur_base[p] == $past(prog_base[p]));
  end
endmodule

// File: rtl/fbase_irq.sv
module fbase_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic vsync,
  input  logic clr_hit,
  input  logic irq_mask,
  output logic stat_q,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (!rst_n)       stat_q <= 1'b0;
    else if (vsync)   stat_q <= 1'b1;
    else if (clr_hit) stat_q <= 1'b0;
  end

  assign irq = stat_q & irq_mask;

  // R6: vsync sets the flag
  a_r6_status_set: assert property (@(posedge clk) disable iff (!rst_n)
    vsync |=> stat_q);
  // R7: clear without vsync drops the flag
  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_hit && !vsync) |=> !stat_q);
  // R8: the interrupt never shows without the flag
  a_r8_irq_needs_status: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> stat_q);
endmodule

// File: rtl/fbase_shadow.sv
module fbase_shadow
  import fbase_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vsync,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [DATA_W-1:0] cur_upper,
  output logic [DATA_W-1:0] cur_lower,
  output logic              irq
);
  logic [NUM_PANELS-1:0][DATA_W-1:0] prog_base;
  logic [NUM_PANELS-1:0][DATA_W-1:0] cur_base;
  logic ctrl_en, irq_mask, clr_hit, load_evt, stat_q;

  fbase_regbank u_regbank (
    .clk, .rst_n, .bus_sel, .bus_wr, .bus_addr, .bus_wdata,
    .prog_base, .ctrl_en, .irq_mask, .clr_hit
  );

  fbase_current u_current (
    .clk, .rst_n, .vsync, .ctrl_en, .prog_base, .cur_base, .load_evt
  );

  fbase_irq u_irq (
    .clk, .rst_n, .vsync, .clr_hit, .irq_mask, .stat_q, .irq
  );

  assign cur_upper = cur_base[0];
  assign cur_lower = cur_base[1];

  always_comb begin
    bus_rdata = '0;
    case (decode_ofs(bus_addr))
      SEL_CTRL:  bus_rdata[0] = ctrl_en;
      SEL_UPPER: bus_rdata    = prog_base[0];
      SEL_LOWER: bus_rdata    = prog_base[1];
      SEL_MASK:  bus_rdata[0] = irq_mask;
      SEL_RAW:   bus_rdata[0] = stat_q;
      SEL_MSTAT: bus_rdata[0] = irq;
      default:   bus_rdata    = '0;
    endcase
  end

  // R2: base registers never read back a nonzero low pair
  a_r2_read_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && (bus_addr == OFS_UPPER || bus_addr == OFS_LOWER))
      |-> bus_rdata[ALIGN_BITS-1:0] == '0);
endmodule

// File: tb/fbase_shadow_bench.sv
module fbase_shadow_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vsync = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata, cur_upper, cur_lower;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    int          what;  // 0 rdata, 1 cur_upper, 2 cur_lower, 3 irq
    logic [31:0] exp;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #5 clk = ~clk;

  fbase_shadow u_fbase_shadow (
    .clk, .rst_n, .vsync, .bus_sel, .bus_wr, .bus_addr, .bus_wdata,
    .bus_rdata, .cur_upper, .cur_lower, .irq
  );

  // monitor: compare one queued expectation per cycle, away from the edge
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t it;
      logic [31:0] got;
      it = sb.pop_front();
      case (it.what)
        0: got = bus_rdata;
        1: got = cur_upper;
        2: got = cur_lower;
        default: got = {31'b0, irq};
      endcase
      checks++;
      if (got !== it.exp) begin
        errors++;
        $display("FAIL %s: got %h expected %h", it.tag, got, it.exp);
      end
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d, input logic vs = 1'b0);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d; vsync = vs;
    step();
    bus_sel = 0; bus_wr = 0; vsync = 0;
  endtask

  task automatic pulse_vsync();
    vsync = 1; step(); vsync = 0;
  endtask

  task automatic rd_chk(input logic [4:0] a, input logic [31:0] e, input string tag);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    sb.push_back('{0, e, tag});
    step();
    bus_sel = 0;
  endtask

  task automatic port_chk(input int w, input logic [31:0] e, input string tag);
    sb.push_back('{w, e, tag});
    step();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    step();
    // R1 reset state
    rd_chk(5'h04, 32'h0, "R1 upper base");
    rd_chk(5'h08, 32'h0, "R1 lower base");
    rd_chk(5'h10, 32'h0, "R1 status");
    rd_chk(5'h00, 32'h0, "R1 enable");
    port_chk(1, 32'h0, "R1 cur_upper");
    port_chk(3, 32'h0, "R1 irq");
    // R2 aligned storage
    wr(5'h04, 32'h1234_5677);
    wr(5'h08, 32'hABCD_EF03);
    rd_chk(5'h04, 32'h1234_5674, "R2 upper readback");
    rd_chk(5'h08, 32'hABCD_EF00, "R2 lower readback");
    // R3 no change without load event
    port_chk(1, 32'h0, "R3 cur_upper held");
    port_chk(2, 32'h0, "R3 cur_lower held");
    // R4 vsync copy, R6 status set
    pulse_vsync();
    port_chk(1, 32'h1234_5674, "R4 cur_upper after vsync");
    port_chk(2, 32'hABCD_EF00, "R4 cur_lower after vsync");
    rd_chk(5'h10, 32'h1, "R6 status set");
    port_chk(3, 32'h0, "R8 irq masked off");
    rd_chk(5'h14, 32'h0, "R8 masked status off");
    // R8 mask on
    wr(5'h0C, 32'h1);
    port_chk(3, 32'h1, "R8 irq asserted");
    rd_chk(5'h14, 32'h1, "R8 masked status on");
    port_chk(3, 32'h1, "R8 irq still asserted");
    // R7 clear
    wr(5'h18, 32'h0);
    rd_chk(5'h10, 32'h1, "R7 clear with 0 ignored");
    wr(5'h18, 32'h1);
    rd_chk(5'h10, 32'h0, "R7 status cleared");
    port_chk(3, 32'h0, "R7 irq dropped");
    // R4 same-cycle write and vsync
    wr(5'h04, 32'h2000_0000, 1'b1);
    port_chk(1, 32'h1234_5674, "R4 collision keeps old value");
    rd_chk(5'h10, 32'h1, "R6 status on collision vsync");
    pulse_vsync();
    port_chk(1, 32'h2000_0000, "R4 new value at next vsync");
    // R7 clear colliding with vsync
    wr(5'h18, 32'h1, 1'b1);
    rd_chk(5'h10, 32'h1, "R7 vsync wins over clear");
    // R9 read-only and unmapped
    wr(5'h10, 32'h0);
    rd_chk(5'h10, 32'h1, "R9 raw status write ignored");
    wr(5'h14, 32'h0);
    rd_chk(5'h14, 32'h1, "R9 masked status write ignored");
    rd_chk(5'h1C, 32'h0, "R9 unmapped reads zero");
    // R5 enable rise
    wr(5'h18, 32'h1);
    wr(5'h04, 32'h3000_0004);
    wr(5'h08, 32'h5000_0008);
    wr(5'h00, 32'h1);
    step();
    port_chk(1, 32'h3000_0004, "R5 upper loaded on enable rise");
    port_chk(2, 32'h5000_0008, "R5 lower loaded on enable rise");
    rd_chk(5'h10, 32'h0, "R6 enable load leaves status clear");
    wr(5'h04, 32'h4000_0000);
    wr(5'h00, 32'h1);
    step();
    port_chk(1, 32'h3000_0004, "R5 no load while already enabled");
    rd_chk(5'h00, 32'h1, "R5 enable reads back");
    step();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule